// File: doc/BRIEF.md
# Register bus address-space splitter

This block lets one register bus master reach several register slaves. Each slave port owns an address window that is fixed at elaboration by a base address and a log2 window size, so a window always covers a power-of-two range. A read or write strobe from the master goes, in the same cycle, only to the slave whose window holds the address. The address and write data go to every slave port unchanged.

When a strobe arrives, the block records which port it selected. Until that access ends, it passes that port's handshake responses and gated read data back to the master. An access ends when the slave gives any response or when a new strobe arrives. An address that falls in no window strobes no slave. The block then answers with unknown-address itself in the next cycle. When windows overlap, the lowest-numbered port owns the shared addresses. Timeouts for slaves that never answer are the master's concern.

Top module: `regbus_splitter`

## Requirements
- R1: A strobe whose 16-bit address lies in port k's window (base to base + 2^bits − 1) raises only bit k of the slave read-strobe vector (for a read) or the slave write-strobe vector (for a write), in the same cycle. Bit k of each vector belongs to port k.
- R2: When an address lies in several windows, only the lowest-numbered of those ports is strobed.
- R3: Every slave port's address and write-data outputs equal the master's address and write data. Port k occupies bits [16k+15:16k] of the address vector and bits [32k+31:32k] of the data vector.
- R4: A strobe that matches no window strobes no slave. It makes the master unknown-address output high for exactly one cycle, in the cycle after the strobe.
- R5: While an access is open, the selected slave's data-ready, no-more-data, write-acknowledge and unknown-address inputs appear on the master outputs in the same cycle.
- R6: Response inputs from slaves that are not selected have no effect on the master outputs.
- R7: Any response from the selected slave ends the access. The block forwards no further responses from that slave until a new strobe arrives.
- R8: Master read data equals the selected slave's read data in a cycle where its data-ready is forwarded. In every other cycle it is zero.
- R9: A new strobe during an open access moves forwarding to the newly selected port. Responses from the previous port are then ignored.
- R10: During and right after reset, no access is open, and all slave strobes and master response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_rd_i | input | 1 | Master read strobe |
| m_wr_i | input | 1 | Master write strobe |
| m_addr_i | input | 16 | Master address |
| m_wdata_i | input | 32 | Master write data |
| m_rdata_o | output | 32 | Read data returned to master |
| m_dready_o | output | 1 | Data-ready to master |
| m_nomore_o | output | 1 | No-more-data to master |
| m_wack_o | output | 1 | Write acknowledge to master |
| m_unk_o | output | 1 | Unknown address to master |
| s_rd_o | output | N_PORTS | Per-port read strobes |
| s_wr_o | output | N_PORTS | Per-port write strobes |
| s_addr_o | output | 16*N_PORTS | Per-port address |
| s_wdata_o | output | 32*N_PORTS | Per-port write data |
| s_rdata_i | input | 32*N_PORTS | Per-port read data |
| s_dready_i | input | N_PORTS | Per-port data-ready |
| s_nomore_i | input | N_PORTS | Per-port no-more-data |
| s_wack_i | input | N_PORTS | Per-port write acknowledge |
| s_unk_i | input | N_PORTS | Per-port unknown address |

## Verification
The hardest condition to reach from the ports is a response from a slave that no longer owns the bus. This covers a slave that answers after its access has closed, and one that answers after a newer strobe has moved the access to another port. The bench creates both cases. It holds a response high past its first cycle, and it issues a second strobe to a different port before the first port answers. The address sweep also drives responses on every port at once, so the forwarded values show whether the decode picked the right port.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BITS_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic dready;
    logic nomore;
    logic wack;
    logic unk;
  } resp_t;
endpackage

// File: rtl/regbus_win_decode.sv
module regbus_win_decode
  import regbus_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter logic [N_PORTS*ADDR_W-1:0] PORT_BASE = '0,
  parameter logic [N_PORTS*BITS_W-1:0] PORT_BITS = '0,
  localparam int unsigned IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  addr_t            addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_PORTS-1:0] hit_raw;

  for (genvar k = 0; k < N_PORTS; k++) begin : g_win
    localparam int unsigned WB   = int'(PORT_BITS[k*BITS_W +: BITS_W]);
    localparam int unsigned SPAN = (WB >= ADDR_W) ? 32'h1_0000 : (32'h1 << WB);
    localparam addr_t       MASK = addr_t'(~(SPAN - 1));
    localparam addr_t       BASE = PORT_BASE[k*ADDR_W +: ADDR_W];
    assign hit_raw[k] = ((addr_i ^ BASE) & MASK) == '0;
  end

  // lowest index wins on overlap
  always_comb begin
    idx_o = '0;
    for (int k = N_PORTS - 1; k >= 0; k--) begin
      if (hit_raw[k]) idx_o = IDX_W'(k);
    end
  end

  assign hit_o = |hit_raw;
endmodule

// File: rtl/regbus_strobe_fan.sv
module regbus_strobe_fan #(
  parameter int unsigned N_PORTS = 3,
  localparam int unsigned IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [N_PORTS-1:0] s_rd_o,
  output logic [N_PORTS-1:0] s_wr_o
);
  for (genvar k = 0; k < N_PORTS; k++) begin : g_fan
    logic sel;
    assign sel       = hit_i && (idx_i == IDX_W'(k));
    assign s_rd_o[k] = rd_i && sel;
    assign s_wr_o[k] = wr_i && sel;
  end
endmodule

// File: rtl/regbus_resp_merge.sv
module regbus_resp_merge
  import regbus_pkg::*;
#(
  parameter int unsigned N_PORTS = 3
) (
  input  logic [N_PORTS-1:0]        en_i,
  input  logic [N_PORTS*DATA_W-1:0] s_rdata_i,
  input  logic [N_PORTS-1:0]        s_dready_i,
  input  logic [N_PORTS-1:0]        s_nomore_i,
  input  logic [N_PORTS-1:0]        s_wack_i,
  input  logic [N_PORTS-1:0]        s_unk_i,
  output data_t                     rdata_o,
  output resp_t                     resp_o
);
  data_t gated_data [N_PORTS];
  resp_t gated_resp [N_PORTS];

  for (genvar k = 0; k < N_PORTS; k++) begin : g_gate
    logic dr;
    assign dr                   = en_i[k] && s_dready_i[k];
    assign gated_data[k]        = s_rdata_i[k*DATA_W +: DATA_W] & {DATA_W{dr}};
    assign gated_resp[k].dready = dr;
    assign gated_resp[k].nomore = en_i[k] && s_nomore_i[k];
    assign gated_resp[k].wack   = en_i[k] && s_wack_i[k];
    assign gated_resp[k].unk    = en_i[k] && s_unk_i[k];
  end

  always_comb begin
    rdata_o = '0;
    resp_o  = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      rdata_o = rdata_o | gated_data[k];
      resp_o  = resp_o | gated_resp[k];
    end
  end
endmodule

// File: rtl/regbus_splitter.sv
module regbus_splitter
  import regbus_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter logic [N_PORTS*ADDR_W-1:0] PORT_BASE = {16'h8000, 16'h8000, 16'hA000},
  parameter logic [N_PORTS*BITS_W-1:0] PORT_BITS = {5'd12, 5'd6, 5'd8}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      m_rd_i,
  input  logic                      m_wr_i,
  input  logic [ADDR_W-1:0]         m_addr_i,
  input  logic [DATA_W-1:0]         m_wdata_i,
  output logic [DATA_W-1:0]         m_rdata_o,
  output logic                      m_dready_o,
  output logic                      m_nomore_o,
  output logic                      m_wack_o,
  output logic                      m_unk_o,
  output logic [N_PORTS-1:0]        s_rd_o,
  output logic [N_PORTS-1:0]        s_wr_o,
  output logic [N_PORTS*ADDR_W-1:0] s_addr_o,
  output logic [N_PORTS*DATA_W-1:0] s_wdata_o,
  input  logic [N_PORTS*DATA_W-1:0] s_rdata_i,
  input  logic [N_PORTS-1:0]        s_dready_i,
  input  logic [N_PORTS-1:0]        s_nomore_i,
  input  logic [N_PORTS-1:0]        s_wack_i,
  input  logic [N_PORTS-1:0]        s_unk_i
);
  localparam int unsigned IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             strobe;
  logic             open_q, miss_q;
  logic [IDX_W-1:0] cur_q;
  logic [N_PORTS-1:0] fwd_en;
  resp_t            resp;
  logic             any_resp;

  assign strobe = m_rd_i || m_wr_i;

  regbus_win_decode #(
    .N_PORTS  (N_PORTS),
    .PORT_BASE(PORT_BASE),
    .PORT_BITS(PORT_BITS)
  ) i_decode (
    .addr_i(m_addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  regbus_strobe_fan #(
    .N_PORTS(N_PORTS)
  ) i_fan (
    .rd_i  (m_rd_i),
    .wr_i  (m_wr_i),
    .hit_i (hit),
    .idx_i (idx),
    .s_rd_o(s_rd_o),
    .s_wr_o(s_wr_o)
  );

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    assign s_addr_o[k*ADDR_W +: ADDR_W]  = m_addr_i;
    assign s_wdata_o[k*DATA_W +: DATA_W] = m_wdata_i;
    assign fwd_en[k] = open_q && (cur_q == IDX_W'(k));
  end

  regbus_resp_merge #(
    .N_PORTS(N_PORTS)
  ) i_merge (
    .en_i      (fwd_en),
    .s_rdata_i (s_rdata_i),
    .s_dready_i(s_dready_i),
    .s_nomore_i(s_nomore_i),
    .s_wack_i  (s_wack_i),
    .s_unk_i   (s_unk_i),
    .rdata_o   (m_rdata_o),
    .resp_o    (resp)
  );

  assign any_resp = resp.dready || resp.nomore || resp.wack || resp.unk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      miss_q <= 1'b0;
      cur_q  <= '0;
    end else if (strobe) begin
      open_q <= hit;
      miss_q <= !hit;
      if (hit) cur_q <= idx;
    end else begin
      miss_q <= 1'b0;
      if (any_resp) open_q <= 1'b0;
    end
  end

  assign m_dready_o = resp.dready;
  assign m_nomore_o = resp.nomore;
  assign m_wack_o   = resp.wack;
  assign m_unk_o    = resp.unk || miss_q;
endmodule

// File: rtl/regbus_splitter_chk.sv
module regbus_splitter_chk #(
  parameter int unsigned N_PORTS = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               m_rd_i,
  input logic               m_wr_i,
  input logic [N_PORTS-1:0] s_rd_o,
  input logic [N_PORTS-1:0] s_wr_o,
  input logic [31:0]        m_rdata_o,
  input logic               m_dready_o,
  input logic               m_wack_o,
  input logic               m_unk_o,
  input logic [N_PORTS-1:0] s_dready_i,
  input logic [N_PORTS-1:0] s_wack_i
);
  assert_single_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_rd_o | s_wr_o));

  assert_rd_origin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|s_rd_o) |-> m_rd_i);

  assert_wr_origin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|s_wr_o) |-> m_wr_i);

  assert_miss_unknown_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_rd_i || m_wr_i) && !(|(s_rd_o | s_wr_o))) |=> (m_unk_o && !m_dready_o && !m_wack_o));

  assert_dready_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_dready_o |-> (|s_dready_i));

  assert_wack_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_wack_o |-> (|s_wack_i));

  assert_rdata_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_dready_o |-> (m_rdata_o == '0));
endmodule

bind regbus_splitter regbus_splitter_chk #(.N_PORTS(N_PORTS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .m_rd_i    (m_rd_i),
  .m_wr_i    (m_wr_i),
  .s_rd_o    (s_rd_o),
  .s_wr_o    (s_wr_o),
  .m_rdata_o (m_rdata_o),
  .m_dready_o(m_dready_o),
  .m_wack_o  (m_wack_o),
  .m_unk_o   (m_unk_o),
  .s_dready_i(s_dready_i),
  .s_wack_i  (s_wack_i)
);

// File: tb/test_regbus_splitter.sv
module test_regbus_splitter;
  localparam int NP = 3;
  localparam logic [NP*16-1:0] BASES = {16'h8000, 16'h8000, 16'hA000};
  localparam logic [NP*5-1:0]  BITS  = {5'd12, 5'd6, 5'd8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_rd = 1'b0, m_wr = 1'b0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic m_dready, m_nomore, m_wack, m_unk;
  logic [NP-1:0] s_rd, s_wr;
  logic [NP*16-1:0] s_addr;
  logic [NP*32-1:0] s_wdata;
  logic [NP*32-1:0] s_rdata;
  logic [NP-1:0] s_dready = '0, s_nomore = '0, s_wack = '0, s_unk = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regbus_splitter #(.N_PORTS(NP), .PORT_BASE(BASES), .PORT_BITS(BITS)) i_regbus_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .m_rd_i(m_rd), .m_wr_i(m_wr), .m_addr_i(m_addr), .m_wdata_i(m_wdata),
    .m_rdata_o(m_rdata), .m_dready_o(m_dready), .m_nomore_o(m_nomore),
    .m_wack_o(m_wack), .m_unk_o(m_unk),
    .s_rd_o(s_rd), .s_wr_o(s_wr), .s_addr_o(s_addr), .s_wdata_o(s_wdata),
    .s_rdata_i(s_rdata), .s_dready_i(s_dready), .s_nomore_i(s_nomore),
    .s_wack_i(s_wack), .s_unk_i(s_unk)
  );

  function automatic logic [31:0] pdata(input int k);
    return 32'hC0DE_0000 + 32'(k) * 32'h0111;
  endfunction

  function automatic int exp_port(input logic [15:0] a);
    for (int k = 0; k < NP; k++) begin
      int b;
      b = int'(BITS[k*5 +: 5]);
      if ((32'(a) >> b) == (32'(BASES[k*16 +: 16]) >> b)) return k;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_resp();
    s_dready = '0; s_nomore = '0; s_wack = '0; s_unk = '0;
  endtask

  // strobe, then answer on every port at once
  task automatic do_access(input logic [15:0] a, input bit wr);
    int p;
    logic [NP-1:0] ev;
    bit fw;
    string rq;
    @(negedge clk);
    clear_resp();
    m_rd = !wr; m_wr = wr; m_addr = a; m_wdata = {a, ~a};
    p  = exp_port(a);
    ev = (p < 0) ? '0 : NP'(1 << p);
    rq = (p == 1) ? "R2" : "R1";
    #1;
    chk(s_rd == (wr ? '0 : ev), rq, 32'(s_rd), 32'(wr ? '0 : ev));
    chk(s_wr == (wr ? ev : '0), rq, 32'(s_wr), 32'(wr ? ev : '0));
    fw = 1'b1;
    for (int k = 0; k < NP; k++)
      if (s_addr[k*16 +: 16] != a || s_wdata[k*32 +: 32] != {a, ~a}) fw = 1'b0;
    chk(fw, "R3", 32'(s_addr[15:0]), 32'(a));
    @(negedge clk);
    m_rd = 1'b0; m_wr = 1'b0;
    if (wr) s_wack = '1; else s_dready = '1;
    #1;
    chk(m_unk == (p < 0), "R4", 32'(m_unk), 32'(p < 0));
    if (wr) begin
      chk(m_wack == (p >= 0) && !m_dready, "R5", 32'(m_wack), 32'(p >= 0));
    end else begin
      chk(m_dready == (p >= 0) && !m_wack, "R6", 32'(m_dready), 32'(p >= 0));
      chk(m_rdata == ((p < 0) ? 32'h0 : pdata(p)), "R8", m_rdata, (p < 0) ? 32'h0 : pdata(p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < NP; k++) s_rdata[k*32 +: 32] = pdata(k);

    // R10 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(s_rd == '0 && s_wr == '0, "R10", 32'({s_rd, s_wr}), 32'h0);
    chk({m_dready, m_nomore, m_wack, m_unk} == 4'b0, "R10", 32'({m_dready, m_nomore, m_wack, m_unk}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    s_dready = '1; s_unk = '1;
    #1;
    chk(!m_dready && !m_unk && m_rdata == '0, "R10", 32'({m_dready, m_unk}), 32'h0);
    clear_resp();

    // boundary addresses
    begin
      logic [15:0] edges [12];
      edges = '{16'h9FFF, 16'hA000, 16'hA0FF, 16'hA100, 16'h7FFF, 16'h8000,
                16'h803F, 16'h8040, 16'h8FFF, 16'h9000, 16'h0000, 16'hFFFF};
      for (int i = 0; i < 12; i++) begin
        do_access(edges[i], 1'b0);
        do_access(edges[i], 1'b1);
      end
    end

    // R7: response held past its first cycle is dropped
    do_access(16'hA010, 1'b0);
    @(negedge clk);
    #1;
    chk(!m_dready && m_rdata == '0, "R7", 32'(m_dready), 32'h0);
    clear_resp();

    // R4: unknown lasts one cycle
    do_access(16'h1234, 1'b0);
    @(negedge clk);
    clear_resp();
    #1;
    chk(!m_unk, "R4", 32'(m_unk), 32'h0);

    // R9: retarget from port0 to port2
    @(negedge clk);
    m_rd = 1'b1; m_addr = 16'hA004;
    @(negedge clk);
    m_addr = 16'h8100;
    #1;
    chk(s_rd == 3'b100, "R9", 32'(s_rd), 32'h4);
    @(negedge clk);
    m_rd = 1'b0; s_dready = 3'b001;
    #1;
    chk(!m_dready && m_rdata == '0, "R9", 32'(m_dready), 32'h0);
    @(negedge clk);
    s_dready = 3'b100;
    #1;
    chk(m_dready && m_rdata == pdata(2), "R9", m_rdata, pdata(2));

    // R5: unknown and no-more-data forwarded
    @(negedge clk);
    clear_resp();
    m_rd = 1'b1; m_addr = 16'h8050;
    @(negedge clk);
    m_rd = 1'b0; s_unk = 3'b100; s_nomore = 3'b011;
    #1;
    chk(m_unk && !m_nomore && !m_dready, "R5", 32'({m_unk, m_nomore}), 32'h2);
    @(negedge clk);
    clear_resp();
    m_wr = 1'b1; m_addr = 16'hA0FF;
    @(negedge clk);
    m_wr = 1'b0; s_nomore = 3'b001; s_wack = 3'b110;
    #1;
    chk(m_nomore && !m_wack, "R5", 32'({m_nomore, m_wack}), 32'h2);

    // sweep
    for (int i = 0; i < 4096; i++) begin
      do_access(16'(i * 16 + (i % 16)), i[0]);
    end

    @(negedge clk);
    clear_resp();
    finish_run();
  end
endmodule